// File: doc/BRIEF.md
# Parallel Tree Reduction Sequencer

This block adds together a bank of partial sums, one per slot, and delivers the grand total. Before a run, software-independent logic upstream loads each slot through a simple write port while the sequencer is idle. A start pulse then launches a series of halving rounds. Each round takes one clock cycle, and in that cycle every active lane adds a partner slot into its own slot. All lanes in a round read the values left by the previous round, so each clock edge acts as the barrier between reduction steps. When the active count reaches one, slot 0 holds the total. The block copies it to the sum output and pulses the done flag.

Two partner orders are selectable, and the order is sampled when start is accepted. In shared order the count is halved with floor, and an odd count folds the stray top element into slot 0. In message order the count is halved with ceiling, and a moving sender limit marks which upper lanes still pass a value down. All values are 32-bit and wrap on overflow. The sequencer has two states. `ST_IDLE` accepts writes and waits for start; start moves it to `ST_RUN`. `ST_RUN` performs one round per cycle and returns to `ST_IDLE` on the cycle whose new count is one.

Top module: `tree_reduce_seq`

## Requirements
- R1: After reset, busy, done and sum_out are all 0.
- R2: With mode=0 (shared order), each round reads count h and sets the new count to h' = floor(h/2). Lane i < h' adds slot i+h'. If h is odd, slot 0 also adds slot h-1. When a run ends, sum_out equals the 32-bit sum of all preloaded slots.
- R3: A start sampled at a rising edge in `ST_IDLE` gives done high in the cycle that follows edge R+1 counted from the start edge. R is the number of halving rounds from NUM_SLOTS down to 1. For the default of 100 slots, R=6 with mode=0 and R=7 with mode=1.
- R4: With mode=1 (message order), h and the limit both begin at NUM_SLOTS, and each round sets h' = ceil(h/2). Lane j adds slot j+h' when j+h' < limit, and the limit then takes h'. When a run ends, sum_out equals the 32-bit sum of all preloaded slots.
- R5: done is high for exactly one cycle per run. sum_out changes only in a cycle where done is high, and it holds while slots are later rewritten.
- R6: A start pulse while busy is ignored. The run ends at its original time and produces no second done.
- R7: busy is high from the cycle after the start edge until the final round commits, and done is never high while busy is.
- R8: Additions wrap modulo 2^32.
- R9: A single nonzero value placed in any one slot, 0 to NUM_SLOTS-1, reaches sum_out unchanged in both orders. No lane sees a same-round update, and no element is counted twice.
- R10: A write issued while busy has no effect on the running reduction's result.
- R11: A change of the mode input during a run has no effect on that run's timing or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a reduction (taken only when idle) |
| mode | input | 1 | 0 = shared order, 1 = message order |
| wr_en | input | 1 | Slot write enable (honoured only when idle) |
| wr_idx | input | SLOT_W (7) | Slot index to write |
| wr_data | input | DATA_W (32) | Value to write |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle pulse: sum_out just loaded |
| sum_out | output | DATA_W (32) | Total of the last completed run |

## Verification
A wrong half or limit counter shows up in two ways at the ports. It moves the done pulse away from its expected cycle, which is visible within a few cycles of start. It also drops or duplicates a slot's contribution, which is visible in sum_out at done. Sweeping a single nonzero slot across every index, in both orders, ties each slot to exactly one path into slot 0. A lane that read a same-round value would therefore return a multiple of that slot's value or zero in the same run. An accepted restart or a stray write while busy shows up as a shifted done pulse or a changed total.

// File: rtl/tree_reduce_pkg.sv
package tree_reduce_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef enum logic {
        ORD_SHARED = 1'b0,
        ORD_MSG    = 1'b1
    } order_e;

endpackage

// File: rtl/tree_reduce_sched.sv
module tree_reduce_sched
    import tree_reduce_pkg::*;
#(
    parameter int NUM_SLOTS = 100,
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    output logic             busy_o,
    output logic             round_o,
    output logic             last_o,
    output order_e           order_o,
    output logic [CNT_W-1:0] half_o,
    output logic [CNT_W-1:0] limit_o,
    output logic [CNT_W-1:0] nxt_half_o
);

    localparam logic [CNT_W-1:0] N_C   = CNT_W'(NUM_SLOTS);
    localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

    seq_state_e       state_q, state_d;
    order_e           order_q;
    logic [CNT_W-1:0] half_q, limit_q, nxt_half;

    // new count for the round in progress
    always_comb begin
        if (order_q == ORD_MSG)
            nxt_half = (half_q >> 1) + {{(CNT_W-1){1'b0}}, half_q[0]};
        else
            nxt_half = half_q >> 1;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i)          state_d = ST_RUN;
            ST_RUN:  if (nxt_half == ONE_C) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // schedule counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= N_C;
            limit_q <= N_C;
            order_q <= ORD_SHARED;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    half_q  <= N_C;
                    limit_q <= N_C;
                    order_q <= order_e'(mode_i);
                end
                ST_RUN: begin
                    half_q <= nxt_half;
                    if (order_q == ORD_MSG) limit_q <= nxt_half;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q == ST_RUN);
        round_o    = (state_q == ST_RUN);
        last_o     = (state_q == ST_RUN) && (nxt_half == ONE_C);
        order_o    = order_q;
        half_o     = half_q;
        limit_o    = limit_q;
        nxt_half_o = nxt_half;
    end

    // each round strictly shrinks the count (R3)
    assert_half_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (half_q < $past(half_q)));

    // sender limit never falls below the count in message order (R4)
    assert_limit_covers_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && order_q == ORD_MSG) |-> (limit_q >= half_q));

    // a start while running does not reload the schedule (R6)
    assert_restart_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start_i) |=> (half_q < $past(half_q)));

    // order stays fixed while a run is in progress (R11)
    assert_order_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> $stable(order_q));

endmodule

// File: rtl/tree_reduce_bank.sv
module tree_reduce_bank
    import tree_reduce_pkg::*;
#(
    parameter int NUM_SLOTS = 100,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1),
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              round_i,
    input  order_e            order_i,
    input  logic [CNT_W-1:0]  half_i,
    input  logic [CNT_W-1:0]  limit_i,
    input  logic [CNT_W-1:0]  nxt_half_i,
    output logic [DATA_W-1:0] slot0_nxt_o
);

    logic [DATA_W-1:0] slot_q   [NUM_SLOTS];
    logic [DATA_W-1:0] lane_nxt [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_lane
        logic [CNT_W:0]    pos;
        logic              take;
        logic [SLOT_W-1:0] pidx;
        logic [DATA_W-1:0] addend, extra;

        // partner selection for this lane
        always_comb begin
            pos = (CNT_W+1)'(g) + {1'b0, nxt_half_i};
            if (order_i == ORD_SHARED)
                take = ((CNT_W+1)'(g) < {1'b0, nxt_half_i});
            else
                take = (pos < {1'b0, limit_i});
            pidx   = take ? pos[SLOT_W-1:0] : '0;
            addend = take ? slot_q[pidx] : '0;
        end

        // odd-count fold lands only on lane 0
        if (g == 0) begin : g_fold
            logic [SLOT_W-1:0] fidx;
            always_comb begin
                fidx  = SLOT_W'(half_i - CNT_W'(1));
                extra = (order_i == ORD_SHARED && half_i[0]) ? slot_q[fidx] : '0;
            end
        end else begin : g_nofold
            always_comb extra = '0;
        end

        always_comb lane_nxt[g] = slot_q[g] + addend + extra;

        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (round_i)
                slot_q[g] <= lane_nxt[g];
            else if (wr_en_i && wr_idx_i == SLOT_W'(g))
                slot_q[g] <= wr_data_i;
        end
    end

    always_comb slot0_nxt_o = lane_nxt[0];

    // the highest slot is only ever a source, never a receiver (R9)
    assert_top_slot_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        round_i |=> $stable(slot_q[NUM_SLOTS-1]));

endmodule

// File: rtl/tree_reduce_seq.sv
module tree_reduce_seq
    import tree_reduce_pkg::*;
#(
    parameter  int NUM_SLOTS = 100,
    parameter  int DATA_W    = 32,
    localparam int CNT_W     = $clog2(NUM_SLOTS + 1),
    localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              mode,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] sum_out
);

    logic              busy_w, round_w, last_w;
    order_e            order_w;
    logic [CNT_W-1:0]  half_w, limit_w, nxt_half_w;
    logic [DATA_W-1:0] slot0_nxt;
    logic              done_q;
    logic [DATA_W-1:0] sum_q;

    tree_reduce_sched #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_sched (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .mode_i    (mode),
        .busy_o    (busy_w),
        .round_o   (round_w),
        .last_o    (last_w),
        .order_o   (order_w),
        .half_o    (half_w),
        .limit_o   (limit_w),
        .nxt_half_o(nxt_half_w)
    );

    tree_reduce_bank #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W),
                       .CNT_W(CNT_W), .SLOT_W(SLOT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (wr_en && !busy_w),
        .wr_idx_i   (wr_idx),
        .wr_data_i  (wr_data),
        .round_i    (round_w),
        .order_i    (order_w),
        .half_i     (half_w),
        .limit_i    (limit_w),
        .nxt_half_i (nxt_half_w),
        .slot0_nxt_o(slot0_nxt)
    );

    // result register: loaded on the final round only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            sum_q  <= '0;
        end else begin
            done_q <= last_w;
            if (last_w) sum_q <= slot0_nxt;
        end
    end

    always_comb begin
        busy    = busy_w;
        done    = done_q;
        sum_out = sum_q;
    end

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    assert_sum_moves_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sum_q) |-> done_q);

    assert_no_done_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> !done_q);

endmodule

// File: tb/sim_tree_reduce_seq.sv
`timescale 1ns/1ps
module sim_tree_reduce_seq;

    localparam int N  = 100;
    localparam int SW = $clog2(N);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0, mode = 1'b0, wr_en = 1'b0;
    logic [SW-1:0] wr_idx = '0;
    logic [31:0]   wr_data = '0;
    logic          busy, done;
    logic [31:0]   sum_out;

    int errors = 0, checks = 0;
    logic [31:0] exp_sum;

    always #4 clk = ~clk;

    tree_reduce_seq #(.NUM_SLOTS(N), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .busy(busy), .done(done), .sum_out(sum_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int kind, input int i, input int k);
        case (kind)
            0: return 32'(i + 1);
            1: return 32'hFFFF_FF00 + 32'(i * 3);
            2: return (i == k) ? 32'(k * 7 + 3) : 32'h0;
            default: return (32'(i) * 32'h9E37_79B9) ^ (32'(i) << 5);
        endcase
    endfunction

    task automatic load(input int kind, input int k);
        exp_sum = '0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_idx = SW'(i); wr_data = pat(kind, i, k);
            exp_sum = exp_sum + pat(kind, i, k);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // inject: 0 none, 1 start while busy, 2 mode flip, 3 write while busy
    task automatic run(input logic md, input int inject, input string req);
        int cnt = 0;
        int exp_cyc = md ? 8 : 7;
        logic seen = 1'b0;
        @(negedge clk);
        start = 1'b1; mode = md;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        check({req, " busy after start (R7)"}, 32'(busy), 32'd1);
        while (!done && cnt < 40) begin
            if (cnt == 3) begin
                if (inject == 1) start = 1'b1;
                if (inject == 2) mode = ~md;
                if (inject == 3) begin wr_en = 1'b1; wr_idx = '0; wr_data = 32'h1234_5678; end
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0; wr_en = 1'b0;
        check({req, " done cycle (R3)"}, 32'(cnt), 32'(exp_cyc));
        check({req, " total"}, sum_out, exp_sum);
        check({req, " busy low at done (R7)"}, 32'(busy), 32'd0);
        @(negedge clk);
        check({req, " done one cycle (R5)"}, 32'(done), 32'd0);
        for (int j = 0; j < 12; j++) begin
            if (done) seen = 1'b1;
            @(negedge clk);
        end
        check({req, " no second done (R6)"}, 32'(seen), 32'd0);
    endtask

    task automatic t_reset;
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 done", 32'(done), 32'd0);
        check("R1 sum_out", sum_out, 32'd0);
    endtask

    task automatic t_orders;
        load(0, 0); run(1'b0, 0, "R2 ramp shared");
        load(0, 0); run(1'b1, 0, "R4 ramp message");
        load(3, 0); run(1'b0, 0, "R2 mixed shared");
        load(3, 0); run(1'b1, 0, "R4 mixed message");
    endtask

    task automatic t_wrap;
        load(1, 0); run(1'b0, 0, "R8 wrap shared");
        load(1, 0); run(1'b1, 0, "R8 wrap message");
    endtask

    task automatic t_sweep;
        for (int k = 0; k < N; k++) begin
            load(2, k); run(1'b0, 0, $sformatf("R9 slot %0d shared", k));
            load(2, k); run(1'b1, 0, $sformatf("R9 slot %0d message", k));
        end
    endtask

    task automatic t_busy_inputs;
        load(0, 0); run(1'b0, 1, "R6 start while busy");
        load(3, 0); run(1'b1, 2, "R11 mode flip");
        load(3, 0); run(1'b0, 3, "R10 write while busy");
    endtask

    task automatic t_hold;
        logic [31:0] keep;
        load(3, 0); run(1'b1, 0, "R5 prep");
        keep = sum_out;
        load(0, 0);
        check("R5 sum held after rewrite", sum_out, keep);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_orders();
        t_wrap();
        t_busy_inputs();
        t_hold();
        t_sweep();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule